// File: doc/BRIEF.md
# Display Raster Timing Generator

This block produces the raster control signals for a display output: horizontal sync, vertical sync, a data-enable window, a field indicator and two single-cycle line-marker pulses. Every position is counted from the first pixel of the sync pulse. A line has a programmable length and sync width, and a frame has a programmable line count and sync height. The active picture is a rectangle inside that raster, given by start and end positions on each axis.

In interlaced operation one vertical counter covers both fields. The span is twice the field line count plus one line. The second field's vertical sync and active window are placed by offsetting the first field's values by the field line count. Software writes the configuration inputs and then pulses a commit strobe. The new settings reach the raster only at the next frame boundary, so a frame never mixes two configurations. A separate blanking input removes the picture at once and leaves the sync signals running.

Top module: `display_timing_gen`

## Requirements
- R1: While reset is held, and on every clock edge at which `enable` is low, the outputs go to idle. Each sync output sits at its inactive level, which is the inverse of its committed polarity bit. Data-enable, the field flag and both line flags are 0. The counters return to position (pixel 0, line 0).
- R2: A line lasts hTotal clocks, where hTotal is `cfgHTiming[31:16]`. Horizontal sync is asserted for pixels p with p < hSyncWidth, where hSyncWidth is `cfgHTiming[15:0]`.
- R3: Data-enable is high when hStart <= p < hEnd and the line l satisfies vStart <= l < vEnd. Here hStart is `cfgHActive[31:16]`, hEnd is `cfgHActive[15:0]`, vStart is `cfgVActive[31:16]` and vEnd is `cfgVActive[15:0]`.
- R4: In progressive mode (`cfgInterlace`=0) a frame lasts vTotal lines, where vTotal is `cfgVTiming[31:16]`. Vertical sync is asserted on lines l < vSyncHeight, where vSyncHeight is `cfgVTiming[15:0]`.
- R5: In interlaced mode (`cfgInterlace`=1) a frame lasts 2*vTotal+1 lines. Vertical sync is also asserted on lines vTotal <= l < vTotal+vSyncHeight.
- R6: In interlaced mode data-enable is also high on lines vTotal+vStart+1 <= l < vTotal+vEnd+1. This second window has the same height as the first.
- R7: The field flag is 1 on lines l >= vTotal in interlaced mode and 0 everywhere else. It is always 0 in progressive mode.
- R8: `cfgPolarity[0]`=1 makes horizontal sync active high and 0 makes it active low. `cfgPolarity[1]` controls vertical sync in the same way.
- R9: `lineFlag0` pulses for one clock at pixel 0 of line E-3. E is the end of the last active window: vEnd in progressive mode and vTotal+vEnd+1 in interlaced mode.
- R10: `lineFlag1` pulses for one clock at pixel 0 of line `cfgLineFlag1`.
- R11: When `blankReq` is high at a clock edge, the data-enable presented after that edge is 0. The sync outputs, the field flag and the line flags are unaffected.
- R12: The configuration inputs have no effect until `cfgDone` is pulsed. A committed set takes effect from the first position of the next frame. While `enable` is low it takes effect on the clock edge after the pulse.
- R13: All outputs are registered. The first clock edge at which `enable` is high presents position (0, 0). Each later enabled edge presents the next position in raster order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the raster; low holds the counters at (0,0) |
| cfgDone | input | 1 | Commit strobe for the configuration inputs |
| cfgHTiming | input | 32 | {line length, horizontal sync width} |
| cfgHActive | input | 32 | {active start pixel, active end pixel} |
| cfgVTiming | input | 32 | {field line count, vertical sync height} |
| cfgVActive | input | 32 | {active start line, active end line} |
| cfgLineFlag1 | input | 16 | Line number for the second line flag |
| cfgInterlace | input | 1 | 1 selects interlaced two-field operation |
| cfgPolarity | input | 2 | Bit 0 sets horizontal sync active high; bit 1 sets vertical sync active high |
| blankReq | input | 1 | Forces data-enable low |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data-enable |
| fieldOut | output | 1 | Field indicator |
| lineFlag0 | output | 1 | Pulse three lines before the last active line ends |
| lineFlag1 | output | 1 | Pulse at the programmed line |

## Verification
Every output is one register stage after the counters. The bench's reference model therefore computes, at each rising edge, the values that position reaches once that edge has passed, and it compares the outputs at the following falling edge. A blanking request applies to the output after the edge at which it is sampled. A committed configuration first shows on the output one edge after the frame-wrap edge, or one edge after the commit pulse while the raster is stopped. The model follows the same edge accounting instead of waiting a fixed delay, so a configuration switch in the middle of a run is checked on the exact clock where it lands.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  parameter int POS_W = 16;
  localparam int LINE_W = POS_W + 1;
  localparam int NUM_FLAGS = 2;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [LINE_W-1:0] line_t;

  typedef struct packed {
    pos_t hTotal;
    pos_t hSyncW;
    pos_t hStart;
    pos_t hEnd;
    pos_t vTotal;
    pos_t vSyncW;
    pos_t vStart;
    pos_t vEnd;
    pos_t lineFlag1;
    logic interlace;
    logic hsHigh;
    logic vsHigh;
  } dtg_cfg_t;

  typedef struct packed {
    logic run;
    logic lineStart;
    logic frameWrap;
  } dtg_strobe_t;
endpackage

// File: rtl/dtg_shadow.sv
module dtg_shadow
  import dtg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     cfgDone,
  input  logic     frameWrap,
  input  dtg_cfg_t cfgIn,
  output dtg_cfg_t activeCfg
);
  dtg_cfg_t stagedCfg;
  logic     pending;
  logic     commit;

  always_comb commit = pending && (frameWrap || !enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stagedCfg <= '0;
      pending   <= 1'b0;
      activeCfg <= '0;
    end else begin
      if (commit) activeCfg <= stagedCfg;
      if (cfgDone) begin
        stagedCfg <= cfgIn;
        pending   <= 1'b1;
      end else if (commit) begin
        pending <= 1'b0;
      end
    end
  end

  // R12
  commit_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> activeCfg == $past(stagedCfg));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(activeCfg));
endmodule

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  pos_t        hTotal,
  input  pos_t        vTotal,
  input  logic        interlace,
  output pos_t        hCnt,
  output line_t       vCnt,
  output dtg_strobe_t strobe
);
  pos_t  lastH;
  line_t lastV;
  logic  atLineEnd;
  logic  atFrameEnd;

  always_comb begin
    lastH      = hTotal - POS_W'(1);
    lastV      = interlace ? {vTotal, 1'b0} : ({1'b0, vTotal} - LINE_W'(1));
    atLineEnd  = (hCnt == lastH);
    atFrameEnd = atLineEnd && (vCnt == lastV);
    strobe.run       = enable;
    strobe.lineStart = (hCnt == '0);
    strobe.frameWrap = enable && atFrameEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!enable) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (atLineEnd) begin
      hCnt <= '0;
      vCnt <= atFrameEnd ? '0 : vCnt + LINE_W'(1);
    end else begin
      hCnt <= hCnt + POS_W'(1);
    end
  end

  // R2
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hTotal != '0) |-> hCnt < hTotal);

  // R5
  vcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && vTotal != '0) |-> vCnt <= lastV);

  // R13
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.frameWrap |=> (hCnt == '0 && vCnt == '0));

  // R1
  idle_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hCnt == '0 && vCnt == '0));
endmodule

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  dtg_strobe_t          strobe,
  input  pos_t                 hCnt,
  input  line_t                vCnt,
  input  dtg_cfg_t             cfg,
  input  logic                 blankReq,
  output logic                 hsyncOut,
  output logic                 vsyncOut,
  output logic                 deOut,
  output logic                 fieldOut,
  output logic [NUM_FLAGS-1:0] flagOut
);
  line_t vTot, vSw, vSt, vEn;
  line_t f1Start, f1End, f1SyncEnd, actEnd;
  logic  hsRaw, vsRaw, hAct, vAct, inField1;
  line_t flagLine [NUM_FLAGS];

  always_comb begin
    vTot      = {1'b0, cfg.vTotal};
    vSw       = {1'b0, cfg.vSyncW};
    vSt       = {1'b0, cfg.vStart};
    vEn       = {1'b0, cfg.vEnd};
    f1Start   = vTot + vSt + LINE_W'(1);
    f1End     = vTot + vEn + LINE_W'(1);
    f1SyncEnd = vTot + vSw;
    inField1  = cfg.interlace && (vCnt >= vTot);
    hsRaw     = hCnt < cfg.hSyncW;
    vsRaw     = (vCnt < vSw) || (inField1 && vCnt < f1SyncEnd);
    hAct      = (hCnt >= cfg.hStart) && (hCnt < cfg.hEnd);
    vAct      = ((vCnt >= vSt) && (vCnt < vEn)) ||
                (cfg.interlace && (vCnt >= f1Start) && (vCnt < f1End));
    actEnd    = cfg.interlace ? f1End : vEn;
    flagLine[0] = actEnd - LINE_W'(3);
    flagLine[1] = {1'b0, cfg.lineFlag1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsyncOut <= 1'b1;
      vsyncOut <= 1'b1;
      deOut    <= 1'b0;
      fieldOut <= 1'b0;
    end else if (!strobe.run) begin
      hsyncOut <= !cfg.hsHigh;
      vsyncOut <= !cfg.vsHigh;
      deOut    <= 1'b0;
      fieldOut <= 1'b0;
    end else begin
      hsyncOut <= cfg.hsHigh ? hsRaw : !hsRaw;
      vsyncOut <= cfg.vsHigh ? vsRaw : !vsRaw;
      deOut    <= hAct && vAct && !blankReq;
      fieldOut <= inField1;
    end
  end

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flagOut[gi] <= 1'b0;
      else        flagOut[gi] <= strobe.run && strobe.lineStart && (vCnt == flagLine[gi]);
    end

    // R9 R10
    flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flagOut[gi] && cfg.hTotal > POS_W'(1)) |=> !flagOut[gi]);
  end

  // R11
  blank_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blankReq |=> !deOut);

  // R7
  field_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.interlace |=> !fieldOut);

  // R7
  field_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.frameWrap |-> ##2 !fieldOut);

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.run |=> (!deOut && !fieldOut && flagOut == '0));
endmodule

// File: rtl/display_timing_gen.sv
module display_timing_gen
  import dtg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cfgDone,
  input  logic [2*POS_W-1:0] cfgHTiming,
  input  logic [2*POS_W-1:0] cfgHActive,
  input  logic [2*POS_W-1:0] cfgVTiming,
  input  logic [2*POS_W-1:0] cfgVActive,
  input  logic [POS_W-1:0]   cfgLineFlag1,
  input  logic               cfgInterlace,
  input  logic [1:0]         cfgPolarity,
  input  logic               blankReq,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic               fieldOut,
  output logic               lineFlag0,
  output logic               lineFlag1
);
  dtg_cfg_t              cfgIn;
  dtg_cfg_t              activeCfg;
  dtg_strobe_t           strobe;
  pos_t                  hCnt;
  line_t                 vCnt;
  logic [NUM_FLAGS-1:0]  flagOut;

  always_comb begin
    cfgIn.hTotal    = cfgHTiming[2*POS_W-1:POS_W];
    cfgIn.hSyncW    = cfgHTiming[POS_W-1:0];
    cfgIn.hStart    = cfgHActive[2*POS_W-1:POS_W];
    cfgIn.hEnd      = cfgHActive[POS_W-1:0];
    cfgIn.vTotal    = cfgVTiming[2*POS_W-1:POS_W];
    cfgIn.vSyncW    = cfgVTiming[POS_W-1:0];
    cfgIn.vStart    = cfgVActive[2*POS_W-1:POS_W];
    cfgIn.vEnd      = cfgVActive[POS_W-1:0];
    cfgIn.lineFlag1 = cfgLineFlag1;
    cfgIn.interlace = cfgInterlace;
    cfgIn.hsHigh    = cfgPolarity[0];
    cfgIn.vsHigh    = cfgPolarity[1];
  end

  dtg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfgDone(cfgDone),
    .frameWrap(strobe.frameWrap), .cfgIn(cfgIn), .activeCfg(activeCfg)
  );

  dtg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hTotal(activeCfg.hTotal), .vTotal(activeCfg.vTotal),
    .interlace(activeCfg.interlace),
    .hCnt(hCnt), .vCnt(vCnt), .strobe(strobe)
  );

  dtg_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .hCnt(hCnt), .vCnt(vCnt),
    .cfg(activeCfg), .blankReq(blankReq),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .fieldOut(fieldOut), .flagOut(flagOut)
  );

  always_comb begin
    lineFlag0 = flagOut[0];
    lineFlag1 = flagOut[1];
  end
endmodule

// File: tb/display_timing_gen_tb.sv
module display_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfgDone = 1'b0;
  logic [31:0] cfgHTiming = '0, cfgHActive = '0, cfgVTiming = '0, cfgVActive = '0;
  logic [15:0] cfgLineFlag1 = '0;
  logic        cfgInterlace = 1'b0;
  logic [1:0]  cfgPolarity = 2'b00;
  logic        blankReq = 1'b0;
  logic        hsyncOut, vsyncOut, deOut, fieldOut, lineFlag0, lineFlag1;

  display_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfgDone(cfgDone),
    .cfgHTiming(cfgHTiming), .cfgHActive(cfgHActive), .cfgVTiming(cfgVTiming),
    .cfgVActive(cfgVActive), .cfgLineFlag1(cfgLineFlag1), .cfgInterlace(cfgInterlace),
    .cfgPolarity(cfgPolarity), .blankReq(blankReq),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .fieldOut(fieldOut),
    .lineFlag0(lineFlag0), .lineFlag1(lineFlag1)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  string hsTag = "R2", vsTag = "R4", deTag = "R3";

  // reference model state
  int mH = 0, mV = 0, span = 1, actEnd = 0;
  int aHT, aHSW, aHS, aHE, aVT, aVSW, aVS, aVE, aLF1;
  bit aIL, aHP, aVP;
  int sHT, sHSW, sHS, sHE, sVT, sVSW, sVS, sVE, sLF1;
  bit sIL, sHP, sVP;
  bit pend = 0, wrap, hsR, vsR, act;
  bit eHs = 1, eVs = 1, eDe = 0, eF = 0, eL0 = 0, eL1 = 0;

  task automatic commitModel();
    aHT = sHT; aHSW = sHSW; aHS = sHS; aHE = sHE;
    aVT = sVT; aVSW = sVSW; aVS = sVS; aVE = sVE; aLF1 = sLF1;
    aIL = sIL; aHP = sHP; aVP = sVP;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      sHT = 0; sHSW = 0; sHS = 0; sHE = 0; sVT = 0; sVSW = 0; sVS = 0; sVE = 0;
      sLF1 = 0; sIL = 0; sHP = 0; sVP = 0;
      commitModel();
      pend = 0; mH = 0; mV = 0;
      eHs = 1; eVs = 1; eDe = 0; eF = 0; eL0 = 0; eL1 = 0;
    end else begin
      wrap = 0;
      if (!enable) begin
        eHs = !aHP; eVs = !aVP; eDe = 0; eF = 0; eL0 = 0; eL1 = 0;
        mH = 0; mV = 0;
        if (pend) begin commitModel(); pend = 0; end
      end else begin
        span = aIL ? 2 * aVT + 1 : aVT;
        hsR = mH < aHSW;
        vsR = (mV < aVSW) || (aIL && mV >= aVT && mV < aVT + aVSW);
        act = (mH >= aHS && mH < aHE) &&
              ((mV >= aVS && mV < aVE) || (aIL && mV >= aVT + aVS + 1 && mV < aVT + aVE + 1));
        actEnd = aIL ? aVT + aVE + 1 : aVE;
        eHs = aHP ? hsR : !hsR;
        eVs = aVP ? vsR : !vsR;
        eDe = act && !blankReq;
        eF  = aIL && mV >= aVT;
        eL0 = (mH == 0) && (mV == actEnd - 3);
        eL1 = (mH == 0) && (mV == aLF1);
        mH++;
        if (mH >= aHT) begin
          mH = 0; mV++;
          if (mV >= span) begin mV = 0; wrap = 1; end
        end
        if (wrap && pend) begin commitModel(); pend = 0; end
      end
      if (cfgDone) begin
        sHT = cfgHTiming[31:16]; sHSW = cfgHTiming[15:0];
        sHS = cfgHActive[31:16]; sHE = cfgHActive[15:0];
        sVT = cfgVTiming[31:16]; sVSW = cfgVTiming[15:0];
        sVS = cfgVActive[31:16]; sVE = cfgVActive[15:0];
        sLF1 = cfgLineFlag1; sIL = cfgInterlace;
        sHP = cfgPolarity[0]; sVP = cfgPolarity[1];
        pend = 1;
      end
    end
  end

  task automatic cmp(input logic actual, input bit expected, input string tag, input string name);
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s %s at t=%0t: actual=%0b expected=%0b", tag, name, $time, actual, expected);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      cmp(hsyncOut, eHs, hsTag, "hsync");
      cmp(vsyncOut, eVs, vsTag, "vsync");
      cmp(deOut, eDe, deTag, "de");
      cmp(fieldOut, eF, "R7", "field");
      cmp(lineFlag0, eL0, "R9", "lineFlag0");
      cmp(lineFlag1, eL1, "R10", "lineFlag1");
    end
  end

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at t=%0t: actual=%0d expected=%0d", tag, $time, actual, expected);
    end
  endtask

  task automatic setCfg(input int ht, hsw, hs, he, vt, vsw, vs, ve, lf1,
                        input bit il, input bit [1:0] pol);
    cfgHTiming   = {ht[15:0], hsw[15:0]};
    cfgHActive   = {hs[15:0], he[15:0]};
    cfgVTiming   = {vt[15:0], vsw[15:0]};
    cfgVActive   = {vs[15:0], ve[15:0]};
    cfgLineFlag1 = lf1[15:0];
    cfgInterlace = il;
    cfgPolarity  = pol;
  endtask

  task automatic pulseDone();
    cfgDone = 1'b1;
    @(negedge clk);
    cfgDone = 1'b0;
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    finish();
  end

  int deSeen;

  initial begin
    runCycles(4);
    // R1: reset state
    check(hsyncOut === 1'b1 && vsyncOut === 1'b1, "R1 sync idle in reset", hsyncOut + 2 * vsyncOut, 3);
    check(deOut === 1'b0 && fieldOut === 1'b0 && lineFlag0 === 1'b0 && lineFlag1 === 1'b0,
          "R1 outputs low in reset", deOut, 0);
    rst_n = 1'b1;
    runCycles(2);

    // progressive config, active-low syncs, committed while stopped (R12)
    setCfg(10, 2, 3, 8, 8, 1, 2, 6, 4, 1'b0, 2'b00);
    pulseDone();
    runCycles(2);
    enable = 1'b1;
    @(negedge clk);
    // R13: first enabled edge presents (0,0): both syncs asserted (low)
    check(hsyncOut === 1'b0 && vsyncOut === 1'b0, "R13 first position", hsyncOut + 2 * vsyncOut, 0);
    runCycles(240);

    // R12: input changes without commit must not alter the raster
    hsTag = "R12"; vsTag = "R12"; deTag = "R12";
    setCfg(14, 5, 1, 13, 9, 3, 1, 8, 2, 1'b1, 2'b11);
    runCycles(160);

    // interlaced, active-high syncs, committed mid-frame (R5 R6 R8)
    hsTag = "R8"; vsTag = "R5"; deTag = "R6";
    setCfg(12, 3, 4, 10, 7, 2, 2, 5, 9, 1'b1, 2'b11);
    runCycles(37);
    pulseDone();
    runCycles(560);

    // R11: blanking keeps syncs, drops DE
    deTag = "R11";
    blankReq = 1'b1;
    deSeen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (deOut === 1'b1) deSeen++;
    end
    check(deSeen == 0, "R11 de during blank", deSeen, 0);
    blankReq = 1'b0;
    runCycles(200);

    // back to progressive, hsync high, vsync low, line flag at line 0
    hsTag = "R8"; vsTag = "R4"; deTag = "R3";
    setCfg(9, 1, 2, 7, 6, 2, 1, 5, 0, 1'b0, 2'b01);
    pulseDone();
    runCycles(300);

    // R1: disable returns to idle with committed polarity
    enable = 1'b0;
    @(negedge clk);
    check(hsyncOut === 1'b0 && vsyncOut === 1'b1, "R1 idle levels after disable", hsyncOut + 2 * vsyncOut, 2);
    check(deOut === 1'b0 && fieldOut === 1'b0, "R1 de/field low after disable", deOut, 0);
    runCycles(4);
    finish();
  end
endmodule